// File: doc/BRIEF.md
# Clock Sync Status Accrual Unit

This unit collects status for one node of a dual-channel time-triggered bus controller. For the symbol window on each of channels A and B it keeps four sticky flags. The flags record a transmit conflict, media activity at a window boundary, a syntax error, and reception of a valid media access test symbol. The flags accrue across every slot, whether or not the slot is assigned to this node. Software clears a flag by writing one to its bit, and a run command clears all of them at once.

The unit also keeps a 4-bit saturating count of consecutive even/odd cycle pairs that closed without any clock correction, because sync frames were missing. The count stops at whichever of two configured limits it reaches first. It returns to zero in three cases: on reset, when the protocol state enters normal-active, and when a pair computes both correction terms successfully.

The event strobes come from the channel decoders and the clock sync logic, one cycle each. Reset is asserted asynchronously and released through an internal two-stage synchronizer, so the unit leaves reset two clock edges after `rst_n` rises.

Top module: `sync_status_accrual`

## Requirements
- R1: An event strobe sets its flag on the next clock edge. In `evt_a` and `evt_b`, bit 0 is transmit conflict, bit 1 is boundary violation, bit 2 is syntax error and bit 3 is valid test symbol. `status_flags[3:0]` holds channel A and `status_flags[7:4]` holds channel B, with the same bit order.
- R2: A set flag stays set until a software clear, a run command or a reset.
- R3: When `wr_en` is high, a 1 in `wr_data[k]` clears `status_flags[k]` on the next edge. A 0 in `wr_data[k]` leaves that flag unchanged.
- R4: When a flag's event and a software clear of that flag occur in the same cycle, the flag ends up set.
- R5: `run_cmd` clears all eight flags on the next edge. Any event strobed in the same cycle still sets its flag.
- R6: After reset, `status_flags` is 0 and `fail_cnt` is 0.
- R7: A cycle with `pair_end` and `corr_missing` high adds one to `fail_cnt`.
- R8: `fail_cnt` does not advance while it equals `lim_fatal` or `lim_passive`.
- R9: `fail_cnt` clears on the edge where `poc_state` becomes 3'd2 (normal-active) after holding a different value. Staying at 3'd2 does not clear it.
- R10: A cycle with `pair_end` and `corr_both_ok` high clears `fail_cnt`.
- R11: When a clear condition (R9 or R10) and an increment condition occur in the same cycle, `fail_cnt` becomes 0.
- R12: `fail_cnt` is unchanged in a cycle that has neither a clear condition nor an increment condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_a | input | 4 | Channel A symbol-window event strobes |
| evt_b | input | 4 | Channel B symbol-window event strobes |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 8 | Write-one-to-clear mask |
| run_cmd | input | 1 | Run command, clears all flags |
| pair_end | input | 1 | Strobe at the end of an even/odd cycle pair |
| corr_missing | input | 1 | Pair had no offset or rate correction because sync frames were missing |
| corr_both_ok | input | 1 | Both correction terms were computed in the pair |
| poc_state | input | 3 | Protocol state, where 3'd2 means normal-active |
| lim_fatal | input | 4 | Fatal limit for the counter |
| lim_passive | input | 4 | Passive limit for the counter |
| status_flags | output | 8 | Sticky flags, channel B in the upper nibble |
| fail_cnt | output | 4 | Count of consecutive pairs without correction |

## Verification
Properties check every cycle that each strobe sets its flag, that a one-write clears a flag unless the event arrives with it, that run clears, and that set flags persist otherwise. They also check that the counter steps by one, holds at a limit and drops to zero on either clear path. Only the bench scenarios show the exact numbers the counter reaches under every pair of limits, including limits of zero and limits below the current count. The same is true of the full per-bit write mapping across both channels and the difference between entering normal-active and remaining in it.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  localparam int unsigned SSA_CH_N  = 2;
  localparam int unsigned SSA_EVT_W = 4;
  localparam int unsigned SSA_CNT_W = 4;
  localparam int unsigned SSA_POC_W = 3;

  typedef enum logic [1:0] {
    EV_TX_CONFLICT = 2'd0,
    EV_BOUNDARY    = 2'd1,
    EV_SYNTAX      = 2'd2,
    EV_TEST_SYM    = 2'd3
  } ssa_evt_e;

  localparam logic [SSA_POC_W-1:0] SSA_POC_NORMAL_ACTIVE = 3'd2;
endpackage

// File: rtl/ssa_rst_sync.sv
module ssa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/ssa_flag_bank.sv
module ssa_flag_bank #(
  parameter int unsigned EVT_W = ssa_pkg::SSA_EVT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt,
  input  logic [EVT_W-1:0] clr_mask,
  input  logic             run_clr,
  output logic [EVT_W-1:0] flags
);
  logic [EVT_W-1:0] flag_q;
  logic [EVT_W-1:0] flag_d;
  logic [EVT_W-1:0] kept;

  always_comb begin
    kept   = run_clr ? '0 : (flag_q & ~clr_mask);
    flag_d = kept | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;

  for (genvar k = 0; k < EVT_W; k++) begin : g_chk
    // R1
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[k] |=> flag_q[k]);
    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[k] && !evt[k]) |=> !flag_q[k]);
    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[k] && !clr_mask[k] && !run_clr) |=> flag_q[k]);
    // R5
    run_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_clr && !evt[k]) |=> !flag_q[k]);
  end
endmodule

// File: rtl/ssa_cfail_ctr.sv
module ssa_cfail_ctr #(
  parameter int unsigned             CNT_W  = ssa_pkg::SSA_CNT_W,
  parameter int unsigned             POC_W  = ssa_pkg::SSA_POC_W,
  parameter logic [POC_W-1:0]        POC_NA = ssa_pkg::SSA_POC_NORMAL_ACTIVE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_end,
  input  logic             corr_missing,
  input  logic             corr_both_ok,
  input  logic [POC_W-1:0] poc_state,
  input  logic [CNT_W-1:0] lim_fatal,
  input  logic [CNT_W-1:0] lim_passive,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [POC_W-1:0] poc_prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             na_entry;
  logic             clr;
  logic             at_lim;
  logic             inc;
  logic             cnt_en;

  always_comb begin
    na_entry = (poc_state == POC_NA) && (poc_prev_q != POC_NA);
    clr      = na_entry || (pair_end && corr_both_ok);
    at_lim   = (cnt_q == lim_fatal) || (cnt_q == lim_passive);
    inc      = pair_end && corr_missing && !at_lim;
    cnt_en   = clr || inc;
    cnt_d    = clr ? '0 : (cnt_q + ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) poc_prev_q <= '0;
    else        poc_prev_q <= poc_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R9
  na_entry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    na_entry |=> (cnt_q == '0));
  // R10
  both_ok_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_end && corr_both_ok) |=> (cnt_q == '0));
  // R7
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_end && corr_missing && !clr && !at_lim) |=> (cnt_q == $past(cnt_q) + ONE));
  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_lim && !clr) |=> (cnt_q == $past(cnt_q)));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_end && !na_entry) |=> $stable(cnt_q));
endmodule

// File: rtl/sync_status_accrual.sv
module sync_status_accrual
  import ssa_pkg::*;
#(
  parameter int unsigned CH_N  = SSA_CH_N,
  parameter int unsigned EVT_W = SSA_EVT_W,
  parameter int unsigned CNT_W = SSA_CNT_W,
  parameter int unsigned POC_W = SSA_POC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [EVT_W-1:0]      evt_a,
  input  logic [EVT_W-1:0]      evt_b,
  input  logic                  wr_en,
  input  logic [CH_N*EVT_W-1:0] wr_data,
  input  logic                  run_cmd,
  input  logic                  pair_end,
  input  logic                  corr_missing,
  input  logic                  corr_both_ok,
  input  logic [POC_W-1:0]      poc_state,
  input  logic [CNT_W-1:0]      lim_fatal,
  input  logic [CNT_W-1:0]      lim_passive,
  output logic [CH_N*EVT_W-1:0] status_flags,
  output logic [CNT_W-1:0]      fail_cnt
);
  localparam int unsigned FLAG_W = CH_N * EVT_W;

  logic                  rst_core_n;
  logic [FLAG_W-1:0]     evt_all;
  logic [FLAG_W-1:0]     clr_all;

  assign evt_all = {evt_b, evt_a};
  assign clr_all = wr_en ? wr_data : '0;

  ssa_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    ssa_flag_bank #(.EVT_W(EVT_W)) bank_i (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .evt      (evt_all[c*EVT_W +: EVT_W]),
      .clr_mask (clr_all[c*EVT_W +: EVT_W]),
      .run_clr  (run_cmd),
      .flags    (status_flags[c*EVT_W +: EVT_W])
    );
  end

  ssa_cfail_ctr #(
    .CNT_W  (CNT_W),
    .POC_W  (POC_W),
    .POC_NA (SSA_POC_NORMAL_ACTIVE)
  ) ctr_i (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .pair_end     (pair_end),
    .corr_missing (corr_missing),
    .corr_both_ok (corr_both_ok),
    .poc_state    (poc_state),
    .lim_fatal    (lim_fatal),
    .lim_passive  (lim_passive),
    .cnt          (fail_cnt)
  );

  // R4
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && (evt_all != '0)) |=> ((status_flags & $past(evt_all)) == $past(evt_all)));
endmodule

// File: tb/sync_status_accrual_tb_top.sv
module sync_status_accrual_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt_a = '0, evt_b = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       run_cmd = 1'b0;
  logic       pair_end = 1'b0, corr_missing = 1'b0, corr_both_ok = 1'b0;
  logic [2:0] poc_state = 3'd0;
  logic [3:0] lim_fatal = 4'hF, lim_passive = 4'hF;
  logic [7:0] status_flags;
  logic [3:0] fail_cnt;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sync_status_accrual dut_i (
    .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b),
    .wr_en(wr_en), .wr_data(wr_data), .run_cmd(run_cmd),
    .pair_end(pair_end), .corr_missing(corr_missing), .corr_both_ok(corr_both_ok),
    .poc_state(poc_state), .lim_fatal(lim_fatal), .lim_passive(lim_passive),
    .status_flags(status_flags), .fail_cnt(fail_cnt)
  );

  task automatic chk_flags(input logic [7:0] exp, input string tag);
    checks++;
    if (status_flags !== exp) begin
      errors++;
      $display("FAIL %s flags actual=%h expected=%h", tag, status_flags, exp);
    end
  endtask

  task automatic chk_cnt(input logic [3:0] exp, input string tag);
    checks++;
    if (fail_cnt !== exp) begin
      errors++;
      $display("FAIL %s fail_cnt actual=%0d expected=%0d", tag, fail_cnt, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    evt_a = '0; evt_b = '0; wr_en = 1'b0; wr_data = '0; run_cmd = 1'b0;
    pair_end = 1'b0; corr_missing = 1'b0; corr_both_ok = 1'b0;
  endtask

  task automatic pair(input logic miss, input logic ok);
    pair_end = 1'b1; corr_missing = miss; corr_both_ok = ok;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1-watchdog: run did not finish actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_flags(8'h00, "R6");
    chk_cnt(4'd0, "R6");

    for (int i = 0; i < 8; i++) begin
      logic [7:0] m;
      m = 8'(1) << i;
      {evt_b, evt_a} = m; step();
      chk_flags(m, "R1");
      step(); step();
      chk_flags(m, "R2");
      wr_en = 1'b1; wr_data = 8'h00; step();
      chk_flags(m, "R3 zero write");
      wr_en = 1'b1; wr_data = ~m; step();
      chk_flags(m, "R3 other bits");
      wr_en = 1'b1; wr_data = m; step();
      chk_flags(8'h00, "R3 one write");
      {evt_b, evt_a} = m; wr_en = 1'b1; wr_data = m; step();
      chk_flags(m, "R4");
      run_cmd = 1'b1; step();
      chk_flags(8'h00, "R5");
      {evt_b, evt_a} = m; run_cmd = 1'b1; step();
      chk_flags(m, "R5 with event");
      wr_en = 1'b1; wr_data = 8'hFF; step();
      chk_flags(8'h00, "R3 all ones");
    end
    {evt_b, evt_a} = 8'hFF; step();
    chk_flags(8'hFF, "R1 all");
    wr_en = 1'b1; wr_data = 8'h5A; step();
    chk_flags(8'hA5, "R3 mixed");
    run_cmd = 1'b1; step();
    chk_flags(8'h00, "R5 all");

    poc_state = 3'd2; step();
    for (int f = 0; f < 16; f++) begin
      for (int p = 0; p < 16; p++) begin
        lim_fatal = 4'(f); lim_passive = 4'(p);
        pair(1'b0, 1'b1);
        chk_cnt(4'd0, "R10");
        exp = 4'd0;
        for (int s = 0; s < 17; s++) begin
          pair(1'b1, 1'b0);
          if (exp != 4'(f) && exp != 4'(p)) exp = exp + 4'd1;
          chk_cnt(exp, "R7/R8 sweep");
        end
        pair(1'b0, 1'b0);
        chk_cnt(exp, "R12");
      end
    end

    lim_fatal = 4'hF; lim_passive = 4'hF;
    pair(1'b0, 1'b1);
    for (int s = 0; s < 5; s++) pair(1'b1, 1'b0);
    chk_cnt(4'd5, "R7");
    pair(1'b1, 1'b1);
    chk_cnt(4'd0, "R11 both_ok");
    for (int s = 0; s < 3; s++) pair(1'b1, 1'b0);
    poc_state = 3'd1; step();
    chk_cnt(4'd3, "R12 state change");
    poc_state = 3'd2; step();
    chk_cnt(4'd0, "R9 entry");
    pair(1'b1, 1'b0); pair(1'b1, 1'b0);
    chk_cnt(4'd2, "R9 staying");
    poc_state = 3'd0; step();
    poc_state = 3'd2; pair(1'b1, 1'b0);
    chk_cnt(4'd0, "R11 entry");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule